// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Master

This block loads a configuration bitstream into a downstream FPGA through a one-bit serial configuration port. The bitstream arrives as bytes on a valid/ready stream. The block drives the target's active-low reset-for-configuration pin, its configuration clock and its serial data pin. It watches the target's active-low initialisation flag and its completion flag, and handles the whole sequence without software help. First it pulses the reset pin and waits for the target to clear its memory. Then it shifts the bytes out one bit at a time, checking for a target-side integrity fault before each byte. Finally it keeps clocking until the target reports completion.

A one-cycle `start_i` pulse launches a load. The outcome appears as a one-cycle `status_valid_o` pulse with a code on `status_code_o`. The code stays on that output until the next report. A readback request is refused, because this serial port cannot return data.

The stream follows these back-pressure rules. Once `in_valid_i` is high, the producer keeps it high and keeps `in_data_i` and `in_last_i` unchanged until it sees `in_ready_o` high on a clock edge. The block raises `in_ready_o` for exactly one cycle per byte, and only after the eighth bit of that byte has been clocked into the target. `in_last_i` marks the final byte of the bitstream.

Top module: `cfg_serial_loader`

## Requirements
- R1: While the block is idle (`busy_o` low), `prog_n_o`, `cclk_o` and `din_o` are all high, and `in_ready_o` is low. This is also the state after reset.
- R2: On `start_i`, `prog_n_o` goes low and stays low until `init_n_i` is seen low. It is then released (driven high).
- R3: After `prog_n_o` is released, no rising edge of `cclk_o` occurs and no byte is accepted until `init_n_i` is high. While `prog_n_o` is low, `cclk_o` stays high.
- R4: Each of the two initialisation waits is limited to TIMEOUT_CYC cycles. If `init_n_i` never goes low, the load ends with code 1 after `prog_n_o` has been low for exactly TIMEOUT_CYC cycles. If `init_n_i` never returns high, the load ends with code 2.
- R5: Each byte is sent MSB first. For each bit, `cclk_o` goes low for CLK_DIV cycles and `din_o` changes at that falling edge. `cclk_o` then stays high for CLK_DIV cycles. `din_o` does not change while `cclk_o` is high during a load.
- R6: `in_ready_o` is high for one cycle per byte. It is raised only in the last cycle of the eighth bit's high clock phase, so every accepted byte has already been fully shifted out.
- R7: Before each byte is started, if `init_n_i` is low while `done_i` is low, the load ends with code 3. No further byte is accepted and no further clock edge is issued.
- R8: After the byte marked `in_last_i` has been sent, `din_o` is held high and `cclk_o` keeps toggling with CLK_DIV-cycle phases until `done_i` is high. The load then ends with code 0.
- R9: If `done_i` does not rise within TIMEOUT_CYC cycles of the start of the trailing clocks, the load ends with code 4.
- R10: A `rdbk_req_i` pulse while idle produces a status pulse with code 5 in the next cycle and leaves every pin unchanged. `rdbk_req_i` is ignored during a load. When `start_i` and `rdbk_req_i` arrive together, the load starts and the request is ignored.
- R11: `status_valid_o` is a single-cycle pulse, and `busy_o` is already low in that cycle. `status_code_o` keeps its value until the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: begin a configuration load (idle only) |
| rdbk_req_i | input | 1 | Pulse: readback request, always refused |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | BYTE_W | Stream byte, sent MSB first |
| in_last_i | input | 1 | Marks the final bitstream byte |
| in_ready_o | output | 1 | Byte accepted (after its last bit is clocked) |
| prog_n_o | output | 1 | Active-low configuration reset to the target |
| cclk_o | output | 1 | Configuration clock, target samples on rising edge |
| din_o | output | 1 | Serial configuration data |
| init_n_i | input | 1 | Target initialisation flag, active low |
| done_i | input | 1 | Target configuration complete |
| busy_o | output | 1 | A load is in progress |
| status_valid_o | output | 1 | One-cycle result strobe |
| status_code_o | output | 3 | 0 ok, 1 init-start timeout, 2 init-clear timeout, 3 integrity error, 4 completion timeout, 5 readback refused |

## Verification
A corrupted bit counter or shift register shows up at the target model as a wrong byte. The mismatch appears one clock phase after the byte's eighth rising edge, or as an acceptance strobe that comes before the byte has been fully captured. A state machine stuck in a wait shows up as the wrong status code: the timeout expires after exactly TIMEOUT_CYC cycles, and the reset pin's low time shows a wrong count by the cycle. A wrong phase in the clock or data path shows up at the very next edge: data moves while the clock is high, a rising edge comes during initialisation, or a trailing clock carries a zero bit.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_HI,
    ST_BYTE,
    ST_SHIFT,
    ST_TRAIL
  } ld_state_e;

  typedef enum logic [2:0] {
    RES_OK            = 3'd0,
    RES_INIT_START_TO = 3'd1,
    RES_INIT_CLEAR_TO = 3'd2,
    RES_INTEGRITY     = 3'd3,
    RES_DONE_TO       = 3'd4,
    RES_NO_READBACK   = 3'd5
  } ld_result_e;

endpackage

// File: rtl/cfg_ld_div.sv
// Clock-phase divider: pulses tick in the last cycle of every CLK_DIV-cycle phase.
module cfg_ld_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] cnt_q;

  assign tick = (cnt_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear || tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_ld_timer.sv
// Wait limiter: expired is high in the LIMIT-th cycle of an uninterrupted run.
module cfg_ld_timer #(
  parameter int LIMIT = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear)           cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_ld_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int CLK_DIV     = 4,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rdbk_req_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              prog_n_o,
  output logic              cclk_o,
  output logic              din_o,
  input  logic              init_n_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              status_valid_o,
  output logic [2:0]        status_code_o
);
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  ld_state_e         state_q, state_d;
  logic [BYTE_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic              last_q;
  logic              prog_n_q, cclk_q, din_q;
  logic              stat_v_q;
  logic [2:0]        stat_code_q;

  logic       ph_tick, ph_clear;
  logic       tmr_clear, tmr_run, tmr_exp;
  logic       byte_end, fin, rdbk_ok;
  ld_result_e fin_code;

  // ---------------------------------------------------------------- helpers
  assign ph_clear = (state_q != state_d) ||
                    !((state_q == ST_SHIFT) || (state_q == ST_TRAIL));

  cfg_ld_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ph_clear),
    .tick  (ph_tick)
  );

  assign tmr_clear = (state_q != state_d);
  assign tmr_run   = (state_q == ST_PROG) || (state_q == ST_WAIT_HI) ||
                     (state_q == ST_TRAIL);

  cfg_ld_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  // end of the high phase of the last bit of a byte
  assign byte_end = (state_q == ST_SHIFT) && cclk_q && ph_tick && (bit_q == LAST_BIT);
  assign rdbk_ok  = (state_q == ST_IDLE) && rdbk_req_i && !start_i;

  // ---------------------------------------------------------------- sequencer
  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_code = RES_OK;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_PROG;
      ST_PROG: begin
        if (!init_n_i) state_d = ST_WAIT_HI;
        else if (tmr_exp) begin
          state_d = ST_IDLE; fin = 1'b1; fin_code = RES_INIT_START_TO;
        end
      end
      ST_WAIT_HI: begin
        if (init_n_i) state_d = ST_BYTE;
        else if (tmr_exp) begin
          state_d = ST_IDLE; fin = 1'b1; fin_code = RES_INIT_CLEAR_TO;
        end
      end
      ST_BYTE: begin
        if (!init_n_i && !done_i) begin
          state_d = ST_IDLE; fin = 1'b1; fin_code = RES_INTEGRITY;
        end else if (in_valid_i) state_d = ST_SHIFT;
      end
      ST_SHIFT:   if (byte_end) state_d = last_q ? ST_TRAIL : ST_BYTE;
      ST_TRAIL: begin
        if (done_i) begin
          state_d = ST_IDLE; fin = 1'b1; fin_code = RES_OK;
        end else if (tmr_exp) begin
          state_d = ST_IDLE; fin = 1'b1; fin_code = RES_DONE_TO;
        end
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  // ---------------------------------------------------------------- pin and shift path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      bit_q    <= '0;
      last_q   <= 1'b0;
      prog_n_q <= 1'b1;
      cclk_q   <= 1'b1;
      din_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      prog_n_q <= (state_d != ST_PROG);
      if (state_d == ST_IDLE) begin
        cclk_q <= 1'b1;
        din_q  <= 1'b1;
      end else if ((state_q == ST_BYTE) && (state_d == ST_SHIFT)) begin
        sh_q   <= in_data_i;
        last_q <= in_last_i;
        bit_q  <= '0;
        cclk_q <= 1'b0;
        din_q  <= in_data_i[BYTE_W-1];
      end else if ((state_q == ST_SHIFT) && (state_d == ST_TRAIL)) begin
        cclk_q <= 1'b0;
        din_q  <= 1'b1;
      end else if ((state_q == ST_SHIFT) && ph_tick && !byte_end) begin
        if (!cclk_q) begin
          cclk_q <= 1'b1;
        end else begin
          cclk_q <= 1'b0;
          din_q  <= sh_q[BYTE_W-2];
          sh_q   <= sh_q << 1;
          bit_q  <= bit_q + 1'b1;
        end
      end else if ((state_q == ST_TRAIL) && ph_tick) begin
        cclk_q <= ~cclk_q;
      end
    end
  end

  // ---------------------------------------------------------------- result reporting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_v_q    <= 1'b0;
      stat_code_q <= 3'd0;
    end else begin
      stat_v_q <= fin || rdbk_ok;
      if (fin)          stat_code_q <= fin_code;
      else if (rdbk_ok) stat_code_q <= RES_NO_READBACK;
    end
  end

  assign in_ready_o     = byte_end;
  assign prog_n_o       = prog_n_q;
  assign cclk_o         = cclk_q;
  assign din_o          = din_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign status_valid_o = stat_v_q;
  assign status_code_o  = stat_code_q;

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_n_o,
  input logic cclk_o,
  input logic din_o,
  input logic busy_o,
  input logic in_ready_o,
  input logic status_valid_o
);
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (prog_n_o && cclk_o && din_o)); // R1
  AST_PROG_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> busy_o); // R2
  AST_NO_CLK_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> cclk_o); // R3
  AST_DIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && cclk_o && $past(cclk_o)) |-> $stable(din_o)); // R5
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |=> !in_ready_o); // R6
  AST_READY_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> (cclk_o && busy_o && prog_n_o)); // R6
  AST_BUSY_END_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> status_valid_o); // R11
  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid_o |-> !busy_o); // R11
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .prog_n_o       (prog_n_o),
  .cclk_o         (cclk_o),
  .din_o          (din_o),
  .busy_o         (busy_o),
  .in_ready_o     (in_ready_o),
  .status_valid_o (status_valid_o)
);

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
  localparam int DIV      = 2;
  localparam int TMO      = 400;
  localparam int INIT_DLY = 20;
  localparam int NROWS    = 8;

  // scenario: 0 normal, 1 init never low, 2 init never high, 3 integrity fault, 4 done never
  typedef struct packed {
    logic [2:0] scen;
    logic [7:0] nb;
    logic [7:0] crc_at;
    logic [7:0] done_after;
    logic [2:0] exp_code;
  } vec_t;

  localparam vec_t VEC [NROWS] = '{
    '{3'd0, 8'd1, 8'd0, 8'd1, 3'd0},
    '{3'd0, 8'd4, 8'd0, 8'd8, 3'd0},
    '{3'd0, 8'd7, 8'd0, 8'd0, 3'd0},
    '{3'd1, 8'd3, 8'd0, 8'd1, 3'd1},
    '{3'd2, 8'd3, 8'd0, 8'd1, 3'd2},
    '{3'd3, 8'd5, 8'd2, 8'd1, 3'd3},
    '{3'd3, 8'd2, 8'd1, 8'd1, 3'd3},
    '{3'd4, 8'd2, 8'd0, 8'd1, 3'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, rdbk_req_i = 1'b0;
  logic in_valid_i = 1'b0, in_last_i = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic init_n_i = 1'b1, done_i = 1'b0;
  logic in_ready_o, prog_n_o, cclk_o, din_o, busy_o, status_valid_o;
  logic [2:0] status_code_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cfg_serial_loader #(.BYTE_W(8), .CLK_DIV(DIV), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rdbk_req_i(rdbk_req_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
    .init_n_i(init_n_i), .done_i(done_i), .busy_o(busy_o),
    .status_valid_o(status_valid_o), .status_code_o(status_code_o)
  );

  function automatic logic [7:0] pat(int r, int i);
    return 8'((r * 29 + i * 71 + 147) ^ (i << 3));
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------------------------------------------------------- target model
  int m_scen = 0, m_nb = 0, m_crc_at = 0, m_done_after = 0, cur_row = 0;
  logic m_prev_cclk = 1'b1, m_prev_prog = 1'b1, m_crc_fault = 1'b0;
  logic [7:0] m_sr = 8'h00;
  logic [7:0] m_cap [16];
  int m_bits = 0, m_nrx = 0, m_trail = 0, m_rel = 0, m_prog_low = 0, m_run = 0;
  int m_lo_len = 0, m_hi_len = 0;
  logic m_rise_init_lo = 0, m_trail_din_bad = 0, m_rel_early = 0, m_ready_bad = 0;
  int f_idx = 0, f_tot = 0;
  logic f_pend = 0, f_en = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (!prog_n_o) begin
        if (m_prev_prog) begin
          m_nrx = 0; m_bits = 0; m_trail = 0; m_crc_fault = 0; done_i = 0;
          m_rel = 0; m_prog_low = 0; m_rise_init_lo = 0; m_trail_din_bad = 0;
          m_rel_early = 0; m_ready_bad = 0; m_lo_len = 0; m_hi_len = 0; m_run = 0;
        end
        m_prog_low++;
        if (m_scen != 1) init_n_i = 1'b0;
      end else begin
        if (!m_prev_prog && init_n_i) m_rel_early = 1;
        if (!init_n_i && !m_crc_fault && m_scen != 2) begin
          m_rel++;
          if (m_rel == INIT_DLY) init_n_i = 1'b1;
        end
        if (cclk_o && !m_prev_cclk) begin
          if (!init_n_i) m_rise_init_lo = 1;
          if (m_nrx < m_nb) begin
            m_sr = {m_sr[6:0], din_o};
            m_bits++;
            if (m_bits == 8) begin
              m_cap[m_nrx] = m_sr; m_nrx++; m_bits = 0;
              if (m_scen == 3 && m_nrx == m_crc_at) begin
                m_crc_fault = 1; init_n_i = 1'b0;
              end
            end
          end else begin
            if (!din_o) m_trail_din_bad = 1;
            m_trail++;
          end
          if (m_nrx == m_nb && m_scen != 4 && m_trail >= m_done_after) done_i = 1'b1;
        end
        if (cclk_o == m_prev_cclk) m_run++;
        else begin
          if (!m_prev_cclk && m_lo_len == 0) m_lo_len = m_run;
          else if (m_prev_cclk && m_lo_len != 0 && m_hi_len == 0) m_hi_len = m_run;
          m_run = 1;
        end
        if (in_ready_o && m_nrx != f_idx + 1) m_ready_bad = 1;
      end
      m_prev_cclk = cclk_o;
      m_prev_prog = prog_n_o;
    end
  end

  // ---------------------------------------------------------------- stream source
  initial begin
    forever begin
      @(negedge clk);
      if (!busy_o) begin
        f_idx = 0; f_pend = 0;
      end else if (f_pend) begin
        f_idx++; f_tot++; f_pend = 0;
      end else if (in_valid_i && in_ready_o) f_pend = 1;
      in_valid_i = f_en && (f_idx < m_nb);
      in_data_i  = pat(cur_row, f_idx);
      in_last_i  = (f_idx == m_nb - 1);
    end
  end

  task automatic wait_status(output int code);
    while (!status_valid_o) @(negedge clk);
    code = int'(status_code_o);
    check("R11 busy low at status", int'(busy_o), 0);
    @(negedge clk);
    check("R11 single-cycle status", int'(status_valid_o), 0);
  endtask

  task automatic load_cfg(int r);
    m_scen = int'(VEC[r].scen); m_nb = int'(VEC[r].nb);
    m_crc_at = int'(VEC[r].crc_at); m_done_after = int'(VEC[r].done_after);
    cur_row = r;
  endtask

  // ---------------------------------------------------------------- main sequence
  initial begin
    int code, tot0, exp_rx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset prog_n", int'(prog_n_o), 1);
    check("R1 reset cclk", int'(cclk_o), 1);
    check("R1 reset din", int'(din_o), 1);
    check("R1 reset busy/ready/status", int'({busy_o, in_ready_o, status_valid_o}), 0);

    for (int r = 0; r < NROWS; r++) begin
      load_cfg(r);
      f_en = 1;
      tot0 = f_tot;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      wait_status(code);
      f_en = 0;
      check($sformatf("R4 R7 R8 R9 row%0d status code", r), code, int'(VEC[r].exp_code));
      exp_rx = (m_scen == 0 || m_scen == 4) ? m_nb : (m_scen == 3) ? m_crc_at : 0;
      check($sformatf("R5 R7 row%0d bytes captured", r), m_nrx, exp_rx);
      for (int j = 0; j < exp_rx; j++)
        check($sformatf("R5 row%0d byte%0d value", r, j), int'(m_cap[j]), int'(pat(r, j)));
      check($sformatf("R6 R7 row%0d bytes accepted", r), f_tot - tot0, exp_rx);
      check($sformatf("R6 row%0d ready after 8th bit", r), int'(m_ready_bad), 0);
      check($sformatf("R3 row%0d no clock while init low", r), int'(m_rise_init_lo), 0);
      check($sformatf("R8 row%0d trailing din high", r), int'(m_trail_din_bad), 0);
      if (m_scen == 1)
        check("R4 prog low length at init-start timeout", m_prog_low, TMO);
      else
        check($sformatf("R2 row%0d prog held until init low", r), int'(m_rel_early), 0);
      check($sformatf("R1 row%0d pins idle after load", r),
            int'({prog_n_o, cclk_o, din_o}), 7);
      repeat (4) @(negedge clk);
    end

    // R10: readback refused while idle, pins untouched
    rdbk_req_i = 1'b1;
    @(negedge clk); rdbk_req_i = 1'b0;
    check("R10 readback status strobe", int'(status_valid_o), 1);
    check("R10 readback code", int'(status_code_o), 5);
    check("R10 pins unchanged", int'({prog_n_o, cclk_o, din_o, busy_o}), 14);
    repeat (5) @(negedge clk);
    check("R11 code held", int'(status_code_o), 5);
    check("R10 still idle", int'({prog_n_o, cclk_o, din_o, busy_o}), 14);

    // R10: start wins over readback, readback during a load is ignored
    load_cfg(1);
    f_en = 1;
    @(negedge clk); start_i = 1'b1; rdbk_req_i = 1'b1;
    @(negedge clk); start_i = 1'b0; rdbk_req_i = 1'b0;
    check("R10 start has priority (busy)", int'(busy_o), 1);
    check("R10 no readback strobe with start", int'(status_valid_o), 0);
    repeat (30) @(negedge clk);
    rdbk_req_i = 1'b1;
    @(negedge clk); rdbk_req_i = 1'b0;
    wait_status(code);
    f_en = 0;
    check("R10 readback during load ignored", code, 0);
    check("R5 low phase length", m_lo_len, DIV);
    check("R5 high phase length", m_hi_len, DIV);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule